// File: doc/BRIEF.md
# Reloading Event Timer with Complementary Buzzer Drive

This block is an 8-bit up-counting timer that can also count external events. Software sets it up over a small register bus. The bus holds a reload value, a control word and two output data bits, and software can read the live count back through it. The count source is one of two. The first is the system clock divided by a power of two, with the exponent picked by a 3-bit field. The second is the rising edges of an asynchronous event input, passed through a synchronizer.

When the counter passes its top value it reloads from the reload register and emits a one-cycle overflow pulse on the same clock edge. Each overflow pulse toggles a divider flip-flop. When buzzer mode is on, that flip-flop drives a complementary pair of pins. Reading the count blocks the count clock for that cycle, so any count arriving during the read is lost.

Register map (2-bit address):
- Address 0: writes go to the reload register, and reads return the live count.
- Address 1: read/write control word. Bits [2:0] are the prescale exponent n. Bit 3 selects the source (1 = event input). Bit 4 is run. Bit 5 is buzzer mode.
- Address 2: read/write output data bits [1:0]. The other bits read as 0.
- Address 3: reads as 0.

Top module: `buzz_timer`

## Requirements
- R1: After reset the count, the control word and the output data bits all read 0, and buzz0, buzz1 and ovfPulse are low.
- R2: With run=1 and source bit 3 = 0, the count advances once every 2^n system clocks, where n is control bits [2:0]. Over 64 consecutive clocks it advances by 64>>n.
- R3: A count step taken at value 8'hFF loads the reload register into the count on that edge, and ovfPulse is high for exactly the following cycle. No other step raises ovfPulse.
- R4: During any cycle in which the count is read (read enable with address 0), the count does not change, and a step due in that cycle is dropped.
- R5: With source bit 3 = 1 and run=1, the count advances once per rising edge of the synchronized eventIn, and the prescale field has no effect.
- R6: With run (bit 4) = 0, the count holds its value whatever the source and prescale settings are.
- R7: A write to address 0 always updates the reload register. It also loads the count only while run=0. While running, the count continues undisturbed.
- R8: Each overflow pulse toggles the divider flip-flop, which starts at 0 after reset.
- R9: In buzzer mode (bit 5 = 1), buzz0 equals divider AND data bit 0, and buzz1 equals NOT divider AND data bit 0. Data bit 1 has no effect on either pin.
- R10: With buzzer mode off, buzz0 follows data bit 0 and buzz1 follows data bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (freezes counting when the address is 0) |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from address |
| eventIn | input | 1 | Asynchronous external event input |
| ovfPulse | output | 1 | One-cycle overflow pulse |
| buzz0 | output | 1 | Pin 0 drive: divider output in buzzer mode |
| buzz1 | output | 1 | Pin 1 drive: complement of the divider in buzzer mode |

## Verification
A count read and a terminal-count overflow can fall in the same cycle. The freeze must win: the overflow is deferred rather than taken. The bench sets up this collision by preloading 8'hFF with n=0. It enables run and holds a count read starting on the very next cycle, which is the cycle whose step would overflow. It then requires the count to stay at 8'hFF with ovfPulse low for the three frozen cycles, and requires the overflow pulse to appear on the first cycle after the read is released.

// File: rtl/buzz_timer_pkg.sv
package buzz_timer_pkg;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned CTRL_W  = SEL_W + 3;
  localparam int unsigned SRC_BIT  = SEL_W;
  localparam int unsigned RUN_BIT  = SEL_W + 1;
  localparam int unsigned BUZZ_BIT = SEL_W + 2;

  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PORT  = 2'd2;

  typedef struct packed {
    logic             countTick;
    logic             preloadWr;
    logic             loadCount;
    logic [CNT_W-1:0] wrData;
    logic             buzzMode;
    logic             dataBit0;
    logic             dataBit1;
  } ctrlStrobes_t;
endpackage

// File: rtl/buzz_timer_ctrl.sv
module buzz_timer_ctrl
  import buzz_timer_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  input  logic              eventIn,
  input  logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  regRdData,
  output ctrlStrobes_t      strb
);
  localparam int unsigned PRE_W = (1 << SEL_W) - 1;

  logic [CTRL_W-1:0] ctrlReg;
  logic [1:0]        portData;
  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W:0]    maskWide;
  logic [SYNC_STAGES-1:0] evSync;
  logic              evPrev;
  logic              intTick, extTick, rawTick, freeze, runOn, wrCount;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      portData <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_CTRL) ctrlReg  <= regWrData[CTRL_W-1:0];
      if (regAddr == ADDR_PORT) portData <= regWrData[1:0];
    end
  end

  // free-running prescaler; a tap every 2^n cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  assign maskWide = ({{PRE_W{1'b0}}, 1'b1} << ctrlReg[SEL_W-1:0]) - 1'b1;
  assign intTick  = &(preCnt | ~maskWide[PRE_W-1:0]);

  // event synchronizer chain and edge detector
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) evSync[0] <= 1'b0;
          else       evSync[0] <= eventIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) evSync[s] <= 1'b0;
          else       evSync[s] <= evSync[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evPrev <= 1'b0;
    else       evPrev <= evSync[SYNC_STAGES-1];
  end

  assign extTick = evSync[SYNC_STAGES-1] & ~evPrev;
  assign rawTick = ctrlReg[SRC_BIT] ? extTick : intTick;
  assign runOn   = ctrlReg[RUN_BIT];
  assign freeze  = regRdEn && (regAddr == ADDR_COUNT);
  assign wrCount = regWrEn && (regAddr == ADDR_COUNT);

  always_comb begin
    strb.countTick = runOn & rawTick & ~freeze;
    strb.preloadWr = wrCount;
    strb.loadCount = wrCount & ~runOn;
    strb.wrData    = regWrData;
    strb.buzzMode  = ctrlReg[BUZZ_BIT];
    strb.dataBit0  = portData[0];
    strb.dataBit1  = portData[1];
  end

  always_comb begin
    case (regAddr)
      ADDR_COUNT: regRdData = countVal;
      ADDR_CTRL:  regRdData = CNT_W'(ctrlReg);
      ADDR_PORT:  regRdData = CNT_W'(portData);
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/buzz_timer_dp.sv
module buzz_timer_dp
  import buzz_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] preloadVal,
  output logic             ovfPulse,
  output logic             pfdState,
  output logic             buzz0,
  output logic             buzz1
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preloadVal <= '0;
    else if (strb.preloadWr) preloadVal <= strb.wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
      ovfPulse <= 1'b0;
    end else begin
      ovfPulse <= 1'b0;
      if (strb.loadCount) begin
        countVal <= strb.wrData;
      end else if (strb.countTick) begin
        if (&countVal) begin
          countVal <= preloadVal;
          ovfPulse <= 1'b1;
        end else begin
          countVal <= countVal + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pfdState <= 1'b0;
    else if (ovfPulse) pfdState <= ~pfdState;
  end

  always_comb begin
    if (strb.buzzMode) begin
      buzz0 = strb.dataBit0 &  pfdState;
      buzz1 = strb.dataBit0 & ~pfdState;
    end else begin
      buzz0 = strb.dataBit0;
      buzz1 = strb.dataBit1;
    end
  end
endmodule

// File: rtl/buzz_timer.sv
module buzz_timer
  import buzz_timer_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  input  logic              eventIn,
  output logic              ovfPulse,
  output logic              buzz0,
  output logic              buzz1
);
  ctrlStrobes_t     strb;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] preloadVal;
  logic             pfdState;

  buzz_timer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .eventIn(eventIn),
    .countVal(countVal), .regRdData(regRdData), .strb(strb)
  );

  buzz_timer_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .countVal(countVal),
    .preloadVal(preloadVal), .ovfPulse(ovfPulse), .pfdState(pfdState),
    .buzz0(buzz0), .buzz1(buzz1)
  );
endmodule

// File: rtl/buzz_timer_chk.sv
module buzz_timer_chk
  import buzz_timer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              ovfPulse,
  input logic              buzz0,
  input logic              buzz1,
  input ctrlStrobes_t      strb,
  input logic [CNT_W-1:0]  countVal,
  input logic [CNT_W-1:0]  preloadVal,
  input logic              pfdState
);
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countTick && (&countVal)) |=> (ovfPulse && countVal == $past(preloadVal)));

  assert_no_spurious_ovf_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.countTick && (&countVal)) |=> !ovfPulse);

  assert_read_freeze_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_COUNT && !regWrEn) |=> $stable(countVal));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countTick && !strb.loadCount) |=> $stable(countVal));

  assert_pfd_toggle_R8: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> (pfdState != $past(pfdState)));

  assert_pfd_still_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ovfPulse |=> $stable(pfdState));

  assert_buzz_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.buzzMode && !strb.dataBit0) |-> (!buzz0 && !buzz1));

  assert_buzz_pair_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.buzzMode && strb.dataBit0) |-> (buzz0 != buzz1));
endmodule

bind buzz_timer buzz_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .ovfPulse(ovfPulse), .buzz0(buzz0), .buzz1(buzz1),
  .strb(strb), .countVal(countVal), .preloadVal(preloadVal),
  .pfdState(pfdState)
);

// File: tb/buzz_timer_test.sv
module buzz_timer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       eventIn = 1'b0;
  logic       ovfPulse, buzz0, buzz1;
  int         testsRun = 0;
  int         testsFailed = 0;
  logic       doneFlag = 1'b0;

  always #2 clk = ~clk;

  buzz_timer uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .eventIn(eventIn), .ovfPulse(ovfPulse), .buzz0(buzz0), .buzz1(buzz1)
  );

  function automatic logic [7:0] ctrlWord(input bit buzz, input bit run,
                                          input bit ext, input logic [2:0] sel);
    return {2'b00, buzz, run, ext, sel};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R1 ovfPulse", {7'd0, ovfPulse}, 8'd0);
    check("R1 buzz pins", {6'd0, buzz1, buzz0}, 8'd0);
    busRead(2'd0, d); check("R1 count", d, 8'h00);
    busRead(2'd1, d); check("R1 control", d, 8'h00);
    busRead(2'd2, d); check("R1 data bits", d, 8'h00);
  endtask

  task automatic testBuzzer();
    int waited;
    busWrite(2'd0, 8'hFF);
    busWrite(2'd2, 8'h03);
    busWrite(2'd1, ctrlWord(1, 0, 0, 3'd7));
    #1 check("R9 divider low pair", {6'd0, buzz1, buzz0}, 8'b10);
    busWrite(2'd2, 8'h02);
    #1 check("R9 data bit1 ignored, both low", {6'd0, buzz1, buzz0}, 8'b00);
    busWrite(2'd2, 8'h01);
    #1 check("R9 data bit0 only enables", {6'd0, buzz1, buzz0}, 8'b10);
    busWrite(2'd1, ctrlWord(1, 1, 0, 3'd7));
    waited = 0;
    while (!ovfPulse && waited < 300) begin
      @(negedge clk); waited++;
    end
    check("R8 overflow seen", {7'd0, ovfPulse}, 8'd1);
    busWrite(2'd1, ctrlWord(1, 0, 0, 3'd7));
    #1 check("R8 divider toggled, pair swapped", {6'd0, buzz1, buzz0}, 8'b01);
    busWrite(2'd1, 8'h00);
    busWrite(2'd2, 8'h02);
    #1 check("R10 plain pins 10", {6'd0, buzz1, buzz0}, 8'b10);
    busWrite(2'd2, 8'h01);
    #1 check("R10 plain pins 01", {6'd0, buzz1, buzz0}, 8'b01);
  endtask

  task automatic testRate(input logic [2:0] sel);
    logic [7:0] d;
    busWrite(2'd0, 8'h00);
    busWrite(2'd1, ctrlWord(0, 1, 0, sel));
    repeat (62) @(negedge clk);
    busWrite(2'd1, ctrlWord(0, 0, 0, sel));
    busRead(2'd0, d);
    check($sformatf("R2 rate n=%0d", sel), d, 8'(64 >> sel));
  endtask

  task automatic testOverflow();
    logic [7:0] d;
    int steps;
    busWrite(2'd0, 8'hFC);
    busWrite(2'd1, ctrlWord(0, 1, 0, 3'd0));
    steps = 0;
    while (!ovfPulse && steps < 20) begin
      @(negedge clk); steps++;
    end
    check("R3 overflow after four steps", 8'(steps), 8'd4);
    regRdEn = 1'b1; regAddr = 2'd0;
    #1 d = regRdData;
    check("R3 reloaded value", d, 8'hFC);
    @(negedge clk);
    check("R3 pulse lasts one cycle", {7'd0, ovfPulse}, 8'd0);
    regRdEn = 1'b0;
    busWrite(2'd1, 8'h00);
  endtask

  task automatic testFreeze();
    logic [7:0] d, first;
    busWrite(2'd0, 8'h00);
    busWrite(2'd1, ctrlWord(0, 1, 0, 3'd0));
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 2'd0;
    #1 first = regRdData;
    repeat (10) @(negedge clk);
    #0 d = regRdData;
    check("R4 count stable while read", d, first);
    regRdEn = 1'b0;
    busWrite(2'd1, 8'h00);
    busRead(2'd0, d);
    check("R4 steps lost during read", d, 8'd3);
  endtask

  task automatic testExternal();
    logic [7:0] d;
    busWrite(2'd0, 8'h00);
    busWrite(2'd1, ctrlWord(0, 1, 1, 3'd2));
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); eventIn = 1'b1;
      repeat (3) @(negedge clk);
      eventIn = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    busWrite(2'd1, 8'h00);
    busRead(2'd0, d);
    check("R5 event edges counted", d, 8'd5);
  endtask

  task automatic testStopped();
    logic [7:0] d;
    busWrite(2'd1, ctrlWord(0, 0, 0, 3'd0));
    busWrite(2'd0, 8'h5A);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); eventIn = 1'b1;
      repeat (3) @(negedge clk); eventIn = 1'b0;
    end
    repeat (10) @(negedge clk);
    busRead(2'd0, d);
    check("R6 stopped count holds", d, 8'h5A);
  endtask

  task automatic testPreloadWrite();
    logic [7:0] d;
    busWrite(2'd0, 8'h80);
    busWrite(2'd1, ctrlWord(0, 1, 0, 3'd0));
    busWrite(2'd0, 8'hF0);
    busWrite(2'd1, 8'h00);
    busRead(2'd0, d);
    check("R7 running write leaves count", d, 8'h84);
    busWrite(2'd0, 8'h33);
    busRead(2'd0, d);
    check("R7 stopped write loads count", d, 8'h33);
  endtask

  task automatic testCollision();
    logic [7:0] d;
    busWrite(2'd0, 8'hFF);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd1; regWrData = ctrlWord(0, 1, 0, 3'd0);
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b1; regAddr = 2'd0;
    for (int k = 0; k < 3; k++) begin
      #1 d = regRdData;
      check("R4 overflow held off by read", d, 8'hFF);
      check("R3 no pulse while frozen", {7'd0, ovfPulse}, 8'd0);
      @(negedge clk);
    end
    regRdEn = 1'b0;
    @(negedge clk);
    check("R3 deferred overflow pulse", {7'd0, ovfPulse}, 8'd1);
    busWrite(2'd1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBuzzer();
    testRate(3'd0);
    testRate(3'd3);
    testOverflow();
    testFreeze();
    testExternal();
    testStopped();
    testPreloadWrite();
    testCollision();
    doneFlag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule